// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Responder

This block is the bit-level front end of a slave on an open-drain single-wire bus with a pull-up. It watches the synchronised line level and turns what the master does into events for the device logic above it. A low period long enough to count as a bus reset is reported, and the block answers it with a presence pulse of its own. Each time slot the master opens with a falling edge is classified from the slot-type selector latched at that edge. A write slot produces one received bit, found by sampling the line at a fixed point. A read slot makes the block pull the line low for a transmitted zero and release it well before the slot ends.

All timing is counted in clock cycles from the master's falling edge or from the end of the reset pulse. The counts are derived from a clocks-per-microsecond parameter. The block has no byte assembly, no command decoding and no addressing. The device logic supplies the bit to send and whether the next slot is a read, and it consumes the received-bit strobe.

Top module: `ow_slave_bit`

## Requirements
- R1: While rst_n is low and on the first cycle after it, drive_low, rx_valid and reset_seen are all 0.
- R2: A low period of RESET_US microseconds that the block is not driving raises reset_seen for exactly one cycle. This holds even if a slot is in progress, and that slot is abandoned.
- R3: After the line rises at the end of a reset, the block waits PRES_WAIT_US microseconds. It then holds drive_low high for PRES_LEN_US microseconds and releases it.
- R4: In a write slot (tx_is_read 0 at the falling edge), rx_valid pulses for one cycle SAMPLE_US microseconds after the falling edge. rx_bit is 1 if the line is high at that point and 0 if it is low.
- R5: In a read slot (tx_is_read 1) with tx_bit 0, drive_low is high from the cycle after the falling edge until HOLD_US microseconds after it. A read slot produces no rx_valid.
- R6: In a read slot with tx_bit 1, drive_low stays 0 for the whole slot.
- R7: tx_bit and tx_is_read are captured at the falling edge. Changing them later in the slot has no effect on that slot.
- R8: The line staying low while the block drives it, including at the release of a presence pulse, never starts a slot. No rx_valid appears until the master makes a new falling edge.
- R9: Slots sent back to back with only 1 microsecond of recovery between them are each decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Synchronised bus line level |
| tx_bit | input | 1 | Bit to send in the next read slot |
| tx_is_read | input | 1 | The next slot is a read slot when 1 |
| drive_low | output | 1 | Pulls the bus line low when 1 |
| rx_valid | output | 1 | One-cycle strobe for a received write bit |
| rx_bit | output | 1 | Value of the received bit |
| reset_seen | output | 1 | One-cycle pulse when a bus reset is detected |

## Verification
Write slots are tried both with a short low time, which reads as a one, and with a low held through the sample point, which reads as a zero. This shows that the sample point lies between the two. Read slots with both transmit values are probed at the line mid-slot and after the hold, which separates driving from not driving and checks that the block releases the line on time. A slot whose selector inputs change after the edge shows whether they are latched at the edge. Reset pulses, both from idle and in the middle of a write slot, are followed by probes of the presence window at its edges. Back-to-back slots with minimal recovery check that the block returns to idle in time.

// File: rtl/ow_slave_bit.sv
module ow_slave_bit #(
  parameter int CLKS_PER_US  = 100,
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LEN_US  = 120,
  parameter int SAMPLE_US    = 30,
  parameter int HOLD_US      = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic tx_bit,
  input  logic tx_is_read,
  output logic drive_low,
  output logic rx_valid,
  output logic rx_bit,
  output logic reset_seen
);
  localparam int RST_C  = CLKS_PER_US * RESET_US;
  localparam int PW_C   = CLKS_PER_US * PRES_WAIT_US;
  localparam int PL_C   = CLKS_PER_US * PRES_LEN_US;
  localparam int SAMP_C = CLKS_PER_US * SAMPLE_US;
  localparam int HOLD_C = CLKS_PER_US * HOLD_US;
  localparam int CW     = $clog2(RST_C + PL_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_SLOT, S_WRISE, S_WAITP, S_PRES} st_t;

  st_t           state;
  logic [CW-1:0] cnt, low_cnt;
  logic          line_q, slot_rd, slot_tx;

  wire fall = line_q & ~line_in;
  assign drive_low = (state == S_PRES) ||
                     (state == S_SLOT && slot_rd && !slot_tx && cnt < CW'(HOLD_C));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      low_cnt    <= '0;
      line_q     <= 1'b1;
      slot_rd    <= 1'b0;
      slot_tx    <= 1'b1;
      rx_valid   <= 1'b0;
      rx_bit     <= 1'b0;
      reset_seen <= 1'b0;
    end else begin
      line_q     <= line_in;
      rx_valid   <= 1'b0;
      reset_seen <= 1'b0;
      if (line_in || drive_low) low_cnt <= '0;
      else if (low_cnt != CW'(RST_C)) low_cnt <= low_cnt + 1'b1;

      if (state != S_WRISE && !line_in && !drive_low && low_cnt == CW'(RST_C - 1)) begin
        state      <= S_WRISE;
        reset_seen <= 1'b1;
      end else begin
        case (state)
          S_IDLE: if (fall) begin
            state   <= S_SLOT;
            cnt     <= '0;
            slot_rd <= tx_is_read;
            slot_tx <= tx_bit;
          end
          S_SLOT: begin
            if (cnt != CW'(RST_C)) cnt <= cnt + 1'b1;
            if (cnt == CW'(SAMP_C - 1) && !slot_rd) begin
              rx_valid <= 1'b1;
              rx_bit   <= line_in;
            end
            if (cnt >= CW'(HOLD_C) && line_in) state <= S_IDLE;
          end
          S_WRISE: if (line_in) begin
            state <= S_WAITP;
            cnt   <= '0;
          end
          S_WAITP: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(PW_C - 1)) begin
              state <= S_PRES;
              cnt   <= '0;
            end
          end
          S_PRES: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(PL_C - 1)) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r4_rx_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r2_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |=> !reset_seen);
  a_r2_reset_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |-> !drive_low);
  a_r5_no_rx_on_own_drive: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(drive_low));
  a_r3_presence_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drive_low) && $past(state) == S_PRES) |-> $past(cnt) == CW'(PL_C - 1));
  a_r8_no_slot_after_presence: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_PRES && state == S_IDLE) |=> state != S_SLOT);
endmodule

// File: tb/test_ow_slave_bit.sv
module test_ow_slave_bit;
  localparam int CPU = 10;
  logic clk = 0, rst_n = 0, m_low = 0, tx_bit = 1, tx_is_read = 0;
  logic drive_low, rx_valid, rx_bit, reset_seen;
  wire line = !(m_low || drive_low);
  int checks = 0, fails = 0, rx_cnt = 0, rst_cnt = 0;
  logic rx_last = 0;

  always #5 clk = ~clk;

  ow_slave_bit #(.CLKS_PER_US(CPU)) i_ow_slave_bit (
    .clk(clk), .rst_n(rst_n), .line_in(line), .tx_bit(tx_bit), .tx_is_read(tx_is_read),
    .drive_low(drive_low), .rx_valid(rx_valid), .rx_bit(rx_bit), .reset_seen(reset_seen));

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_bit; end
    if (reset_seen) rst_cnt++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(int n);
    repeat (n * CPU) @(posedge clk);
    #1;
  endtask

  task automatic probe(string req, int exp);
    @(negedge clk);
    chk(req, line, exp);
    @(posedge clk); #1;
  endtask

  task automatic wslot(int low_us, int total_us);
    m_low = 1; wait_us(low_us);
    m_low = 0; wait_us(total_us - low_us);
  endtask

  task automatic presence_checks(string req);
    wait_us(15); probe({req, " idle before presence"}, 1);
    wait_us(25); probe({req, " presence low"}, 0);
    wait_us(98); probe({req, " presence still low"}, 0);
    wait_us(20); probe({req, " presence released"}, 1);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk("R1 drive_low", drive_low, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 reset_seen", reset_seen, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk("R1 drive_low after", drive_low, 0);
    wait_us(5);
  endtask

  task automatic t_bus_reset;
    int r0 = rst_cnt;
    m_low = 1; wait_us(500);
    chk("R2 reset pulses", rst_cnt - r0, 1);
    m_low = 0;
    presence_checks("R3");
    wait_us(5);
  endtask

  task automatic t_write(bit v);
    int c0 = rx_cnt;
    tx_is_read = 0;
    wslot(v ? 3 : 60, 70); wait_us(1);
    chk("R4 write count", rx_cnt - c0, 1);
    chk("R4 write value", rx_last, v);
  endtask

  task automatic t_read(bit v);
    int c0 = rx_cnt;
    tx_is_read = 1; tx_bit = v;
    m_low = 1; wait_us(2); m_low = 0;
    wait_us(13);
    probe(v ? "R6 read one mid" : "R5 read zero mid", v);
    wait_us(33);
    probe(v ? "R6 read one after" : "R5 released after hold", 1);
    wait_us(20);
    chk("R5 no rx on read", rx_cnt - c0, 0);
    tx_is_read = 0; tx_bit = 1;
  endtask

  task automatic t_latch;
    int c0 = rx_cnt;
    tx_is_read = 1; tx_bit = 0;
    m_low = 1; wait_us(2); m_low = 0;
    wait_us(3);
    tx_is_read = 0; tx_bit = 1;
    wait_us(10);
    probe("R7 latched read zero", 0);
    wait_us(55);
    chk("R7 no rx", rx_cnt - c0, 0);
  endtask

  task automatic t_after_presence;
    int c0;
    m_low = 1; wait_us(500); m_low = 0;
    c0 = rx_cnt;
    wait_us(200);
    chk("R8 no slot from presence", rx_cnt - c0, 0);
    tx_is_read = 0;
    wslot(60, 70); wait_us(1);
    chk("R8 next slot count", rx_cnt - c0, 1);
    chk("R8 next slot value", rx_last, 0);
  endtask

  task automatic t_back_to_back;
    int c0 = rx_cnt;
    tx_is_read = 0;
    wslot(3, 61); wslot(60, 61); wslot(3, 61); wslot(60, 61);
    wait_us(1);
    chk("R9 four bits", rx_cnt - c0, 4);
    chk("R9 last value", rx_last, 0);
  endtask

  task automatic t_reset_mid_slot;
    int r0 = rst_cnt;
    tx_is_read = 0;
    m_low = 1; wait_us(500);
    chk("R2 reset in slot", rst_cnt - r0, 1);
    m_low = 0;
    presence_checks("R2 abandon");
    wait_us(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_bus_reset();
    t_write(1);
    t_write(0);
    t_read(0);
    t_read(1);
    t_latch();
    t_after_presence();
    t_back_to_back();
    t_reset_mid_slot();
    t_write(1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule